// File: doc/BRIEF.md
# Dual-Space Data Memory Router

This block sits between a small microcontroller core and its internal data storage. Every data access arrives with an 8-bit address, a write flag, write data and a flag that says whether the address came from an instruction operand (direct) or from a pointer register (indirect). The block chooses one of three places for the access: the lower 128 bytes of RAM, the upper 128 bytes of RAM, or an external bus that reaches the special-function registers. It holds the 256-byte RAM itself. It returns read data one clock after the request.

Direct and indirect accesses to the bottom half of the address range reach the same RAM bytes. In the top half, the two modes part ways. A direct access there reaches a register on the special-function bus. An indirect access reaches RAM that has the same numeric address. So one address such as 90h names two different bytes, and the core picks between them through the mode flag.

A separate combinational path turns a bit address into a byte address and a bit position. Bit addresses in the top half select bits of registers whose address is a multiple of 8. Bit addresses in the bottom half select bits in a fixed 16-byte window of RAM.

Top module: `dmem_router`

## Requirements
- R1: An access of either mode to addresses 00h..7Fh reaches lower RAM: en_lo is high in the request cycle, and en_hi and en_sfr are low.
- R2: A direct access to 80h..FFh goes to the register bus and never to RAM. en_sfr is high, sfr_addr equals the address, and sfr_rd (for reads) or sfr_wr (for writes) is high. No RAM byte changes.
- R3: An indirect access to 80h..FFh reaches upper RAM at the same numeric address. en_hi is high, and sfr_rd and sfr_wr stay low.
- R4: A write is stored in the target that the R1–R3 rules select for a read, and it takes effect in one clock. A read on the next cycle returns the new value.
- R5: Read data is registered. rd_valid is high for exactly the one cycle after each accepted read, with rd_data holding the result. A write produces no rd_valid.
- R6: sfr_rd and sfr_wr are high only in the cycle in which the matching access is presented, so each access gives one cycle of strobe.
- R7: A register-bus read with sfr_ack low (no register at that address) returns 00h, whatever sfr_rdata carries.
- R8: For bit_addr 80h..FFh: bit_in_sfr is 1, bit_byte is bit_addr with bits [2:0] cleared, and bit_pos is bit_addr[2:0].
- R9: For bit_addr 00h..7Fh: bit_in_sfr is 0, bit_byte is 20h + bit_addr[6:3], and bit_pos is bit_addr[2:0].
- R10: While rst_n is low and right after reset, rd_valid is 0 and rd_data is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_ind | input | 1 | 1 = indirect (pointer) access, 0 = direct |
| acc_addr | input | 8 | Access address |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| en_lo | output | 1 | Access targets lower RAM |
| en_hi | output | 1 | Access targets upper RAM |
| en_sfr | output | 1 | Access targets the register bus |
| sfr_addr | output | 8 | Register bus address |
| sfr_rd | output | 1 | Register bus read strobe |
| sfr_wr | output | 1 | Register bus write strobe |
| sfr_wdata | output | 8 | Register bus write data |
| sfr_rdata | input | 8 | Register bus read data (same cycle as sfr_rd) |
| sfr_ack | input | 1 | A register exists at sfr_addr |
| bit_addr | input | 8 | Bit address to translate |
| bit_byte | output | 8 | Byte address that holds the bit |
| bit_pos | output | 3 | Bit position in that byte |
| bit_in_sfr | output | 1 | Bit belongs to a special-function register |

## Verification
The case that is hardest to show is aliasing: one address must hold two independent values, and a write in one mode must leave the other mode's byte alone. The stimulus writes different values to the same upper address through both modes and then reads back through both modes in the opposite order. It does the same with an address that has no register behind it, so a direct write that gets lost cannot leak into the RAM byte with the same address. Back-to-back reads that alternate between RAM and the register bus show that the registered return data keeps its order.

// File: rtl/dmem_router.sv
module dmem_router #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int BIT_BASE = 'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_we,
  input  logic          acc_ind,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          en_lo,
  output logic          en_hi,
  output logic          en_sfr,
  output logic [AW-1:0] sfr_addr,
  output logic          sfr_rd,
  output logic          sfr_wr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata,
  input  logic          sfr_ack,
  input  logic [AW-1:0] bit_addr,
  output logic [AW-1:0] bit_byte,
  output logic [2:0]    bit_pos,
  output logic          bit_in_sfr
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          upper;
  logic          ram_sel;

  assign upper     = acc_addr[AW-1];
  assign en_lo     = acc_valid & ~upper;
  assign en_hi     = acc_valid & upper & acc_ind;
  assign en_sfr    = acc_valid & upper & ~acc_ind;
  assign ram_sel   = en_lo | en_hi;

  assign sfr_addr  = acc_addr;
  assign sfr_wdata = acc_wdata;
  assign sfr_rd    = en_sfr & ~acc_we;
  assign sfr_wr    = en_sfr & acc_we;

  always_ff @(posedge clk)
    if (ram_sel && acc_we) mem[acc_addr] <= acc_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid & ~acc_we;
      if (acc_valid && !acc_we)
        rd_data <= en_sfr ? (sfr_ack ? sfr_rdata : '0) : mem[acc_addr];
    end
  end

  assign bit_in_sfr = bit_addr[AW-1];
  assign bit_pos    = bit_addr[2:0];
  assign bit_byte   = bit_in_sfr ? {bit_addr[AW-1:3], 3'b000}
                                 : AW'(BIT_BASE) + AW'(bit_addr[AW-2:3]);
endmodule

// File: rtl/dmem_router_chk.sv
module dmem_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_we,
  input logic       acc_ind,
  input logic [7:0] acc_addr,
  input logic       rd_valid,
  input logic       en_lo,
  input logic       en_hi,
  input logic       en_sfr,
  input logic       sfr_rd,
  input logic       sfr_wr
);
  // R1
  targets_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_lo, en_hi, en_sfr}));
  // R1
  low_half_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_addr[7]) |-> (en_lo && !sfr_rd && !sfr_wr));
  // R2
  direct_high_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr[7] && !acc_ind) |-> (en_sfr && !en_hi));
  // R3
  indirect_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ind |-> (!sfr_rd && !sfr_wr));
  // R5
  rd_valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_we) |=> rd_valid);
  // R5
  no_rd_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid || acc_we) |=> !rd_valid);
  // R6
  strobe_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd || sfr_wr) |-> acc_valid);
endmodule

bind dmem_router dmem_router_chk i_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
  .acc_ind(acc_ind), .acc_addr(acc_addr), .rd_valid(rd_valid),
  .en_lo(en_lo), .en_hi(en_hi), .en_sfr(en_sfr),
  .sfr_rd(sfr_rd), .sfr_wr(sfr_wr)
);

// File: tb/test_dmem_router.sv
`timescale 1ns/1ps
module test_dmem_router;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       acc_valid = 0, acc_we = 0, acc_ind = 0;
  logic [7:0] acc_addr = 0, acc_wdata = 0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       en_lo, en_hi, en_sfr;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       sfr_rd, sfr_wr, sfr_ack;
  logic [7:0] bit_addr = 0, bit_byte;
  logic [2:0] bit_pos;
  logic       bit_in_sfr;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] ref_ram [256];
  logic [7:0] sfr_regs [256];
  logic       sfr_here [256];

  always #2 clk = ~clk;

  dmem_router i_dmem_router (.*);

  // register bus model: a few registers exist, the rest answer with garbage and no ack
  assign sfr_ack   = sfr_here[sfr_addr];
  assign sfr_rdata = sfr_here[sfr_addr] ? sfr_regs[sfr_addr] : 8'hA5;
  always @(posedge clk)
    if (sfr_wr && sfr_here[sfr_addr]) sfr_regs[sfr_addr] <= sfr_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected read results
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R5 unexpected rd_valid", 1, 0);
      else chk("R4/R5/R7 read data", rd_data, exp_q.pop_front());
    end
  end

  task automatic access(input logic we, input logic ind, input logic [7:0] a, input logic [7:0] d);
    logic up, bus;
    acc_valid = 1; acc_we = we; acc_ind = ind; acc_addr = a; acc_wdata = d;
    up  = a[7];
    bus = up && !ind;
    #1;
    chk("R1 en_lo", en_lo, !up);
    chk("R3 en_hi", en_hi, up && ind);
    chk("R2 en_sfr", en_sfr, bus);
    chk("R6 sfr_rd", sfr_rd, bus && !we);
    chk("R6 sfr_wr", sfr_wr, bus && we);
    if (bus) chk("R2 sfr_addr", sfr_addr, a);
    if (!we) begin
      if (bus) exp_q.push_back(sfr_here[a] ? sfr_regs[a] : 8'h00);
      else     exp_q.push_back(ref_ram[a]);
    end else if (!bus) ref_ram[a] = d;
    @(negedge clk);
  endtask

  task automatic idle();
    acc_valid = 0; acc_we = 0;
    #1;
    chk("R6 no strobe when idle", {sfr_rd, sfr_wr}, 0);
    @(negedge clk);
  endtask

  task automatic bitchk(input logic [7:0] b);
    bit_addr = b; #1;
    if (b[7]) begin
      chk("R8 bit_byte", bit_byte, {b[7:3], 3'b000});
      chk("R8 bit_in_sfr", bit_in_sfr, 1);
      chk("R8 bit_pos", bit_pos, b[2:0]);
    end else begin
      chk("R9 bit_byte", bit_byte, 8'h20 + b[6:3]);
      chk("R9 bit_in_sfr", bit_in_sfr, 0);
      chk("R9 bit_pos", bit_pos, b[2:0]);
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      sfr_here[i] = 0; sfr_regs[i] = 0; ref_ram[i] = 8'hxx;
    end
    sfr_here[8'h80] = 1; sfr_here[8'h90] = 1; sfr_here[8'hA0] = 1; sfr_here[8'hC8] = 1;
    sfr_regs[8'h90] = 8'h5A;
    repeat (3) @(negedge clk);
    chk("R10 rd_valid in reset", rd_valid, 0);
    chk("R10 rd_data in reset", rd_data, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 rd_valid after reset", rd_valid, 0);

    // R1: lower half reachable both ways
    access(1, 0, 8'h10, 8'h11);
    access(0, 1, 8'h10, 0);
    access(1, 1, 8'h7F, 8'h22);
    access(0, 0, 8'h7F, 0);
    access(0, 0, 8'h00, 0);
    idle();

    // R2/R3 aliasing at 90h
    access(0, 0, 8'h90, 0);          // port value
    access(1, 1, 8'h90, 8'h3C);      // upper RAM
    access(1, 0, 8'h90, 8'h77);      // register
    access(0, 1, 8'h90, 0);          // R3 expect 3C
    access(0, 0, 8'h90, 0);          // R2 expect 77
    access(1, 1, 8'h80, 8'hC1);
    access(0, 0, 8'h80, 0);          // register still 00
    access(0, 1, 8'h80, 0);
    idle();

    // R7 unmapped register, RAM byte at same address untouched
    access(1, 1, 8'hC9, 8'h12);
    access(1, 0, 8'hC9, 8'h55);
    access(0, 0, 8'hC9, 0);          // 00
    access(0, 1, 8'hC9, 0);          // 12
    access(1, 1, 8'hFF, 8'hEE);
    access(0, 1, 8'hFF, 0);
    access(0, 0, 8'hFF, 0);
    idle();

    // R4 back-to-back write then read, several patterns
    for (int i = 0; i < 16; i++) begin
      access(1, i[0], 8'(i * 8 + 3), 8'(i * 17 + 1));
      access(0, 1, 8'(i * 8 + 3), 0);
    end
    for (int i = 0; i < 16; i++) access(0, ~i[0], 8'(i * 8 + 3), 0);
    idle();
    idle();
    chk("R5 queue drained", exp_q.size(), 0);

    // R8/R9 bit translation
    foreach (bit_addr[j]) ; 
    bitchk(8'h00); bitchk(8'h07); bitchk(8'h08); bitchk(8'h7F);
    bitchk(8'h80); bitchk(8'h93); bitchk(8'hCA); bitchk(8'hFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule